// File: doc/BRIEF.md
# Shared-Multiplier Sequential FIR Filter

This block is a finite impulse response filter that spends one multiplier and one adder on all of its taps. An input sample is accepted only while the block is idle. It is shifted into a tap history, and then a tap counter walks through the taps one per clock. In each cycle the counter selects one coefficient and one stored sample, multiplies them, and adds the product into a feedback accumulator. After the last tap, the full-precision sum is latched to the output with a one-cycle valid strobe, and the accumulator starts again from zero.

The tap count, the sample width and the coefficient width are parameters. The coefficients are a packed parameter vector in which tap `i` sits at bits `[i*COEF_W +: COEF_W]`. The output width is `DATA_W + COEF_W + clog2(NUM_TAPS)`, so no sum can overflow. A host that wants one output per sample waits for `busy_o` to fall before it presents the next sample.

Top module: `mac_fir`

## Requirements
- R1: After asynchronous reset, `out_data_o` is 0, `out_valid_o` is 0, `busy_o` is 0, and every stored sample is zero, so the first outputs see a history of zeros.
- R2: A sample offered while `busy_o` is high is ignored. It does not enter the history, and it does not change the current or any later result.
- R3: Each result equals the sum over i of `h[i]*x[i]`, computed as signed two's complement at full precision. `x[0]` is the sample just accepted, `x[i]` is the sample accepted i acceptances earlier, and `h[i]` is the signed field `COEFS[i*COEF_W +: COEF_W]`.
- R4: `out_valid_o` rises exactly NUM_TAPS clock edges after the edge that accepts a sample, and it stays high for one cycle.
- R5: `busy_o` goes high on the accepting edge and falls on the same edge that raises `out_valid_o`.
- R6: Each sweep starts its accumulation from zero, so back-to-back sweeps carry nothing from one result into the next.
- R7: A synchronous clear zeroes `out_data_o`, `out_valid_o` and `busy_o`, and it aborts any sweep in progress. It takes priority over a sample offered in the same cycle, which is not accepted. The stored history is kept.
- R8: `out_data_o` holds its value between valid strobes unless a clear occurs.
- R9: With extreme samples (-2^(DATA_W-1) and 2^(DATA_W-1)-1) in every tap, the result is still exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the sweep and the output |
| in_valid_i | input | 1 | Sample offered |
| in_data_i | input | DATA_W | Signed input sample |
| out_valid_o | output | 1 | One-cycle strobe marking a new result |
| out_data_o | output | DATA_W+COEF_W+clog2(NUM_TAPS) | Signed filter result |
| busy_o | output | 1 | Sweep in progress; new samples are ignored |

## Verification
The hardest situations to reach from the ports are a sample offered during the final cycle of a sweep, and a clear that lands mid-sweep in the same cycle as a new sample. In both cases the result depends on the history that was kept or dropped. The stimulus holds junk samples on the input through random stretches of every sweep, including the last one, and it drives a clear together with an offered sample part way through a sweep. The following sweep exposes any wrong shift, because its result depends on every stored tap. A unit impulse reads out each coefficient in turn, and runs of extreme samples drive the accumulator to its widest values.

// File: rtl/mac_fir_pkg.sv
package mac_fir_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int acc_width(input int dw, input int cw, input int n);
    return dw + cw + $clog2(n);
  endfunction
endpackage

// File: rtl/mac_fir_delay.sv
module mac_fir_delay #(
  parameter int DATA_W   = 16,
  parameter int NUM_TAPS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     shift_i,
  input  logic signed [DATA_W-1:0] din_i,
  input  logic        [IDX_W-1:0]  sel_i,
  output logic signed [DATA_W-1:0] dout_o
);
  logic signed [DATA_W-1:0] hist_q [NUM_TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q[0] <= '0;
    else if (shift_i) hist_q[0] <= din_i;
  end

  for (genvar g = 1; g < NUM_TAPS; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hist_q[g] <= '0;
      else if (shift_i) hist_q[g] <= hist_q[g-1];
    end
  end

  // sample mux feeding the shared multiplier
  always_comb begin
    dout_o = hist_q[0];
    for (int i = 0; i < NUM_TAPS; i++)
      if (sel_i == IDX_W'(i)) dout_o = hist_q[i];
  end
endmodule

// File: rtl/mac_fir_seq.sv
module mac_fir_seq #(
  parameter int NUM_TAPS = 8,
  parameter int IDX_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             in_valid_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o,
  output logic [IDX_W-1:0] cnt_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(NUM_TAPS - 1);

  logic             busy_q;
  logic [IDX_W-1:0] cnt_q;

  assign accept_o = in_valid_i && !busy_q && !clr_i;
  assign last_o   = busy_q && (cnt_q == LastIdx);
  assign busy_o   = busy_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (last_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_START_SWEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_q && cnt_q == '0);                       // R5
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LastIdx);                                         // R4
  AST_IDLE_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> cnt_q == '0);                                  // R4
endmodule

// File: rtl/mac_fir_mac.sv
module mac_fir_mac #(
  parameter int DATA_W   = 16,
  parameter int COEF_W   = 16,
  parameter int NUM_TAPS = 8,
  parameter int IDX_W    = 3,
  parameter int ACC_W    = 35,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     en_i,
  input  logic                     last_i,
  input  logic        [IDX_W-1:0]  sel_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic signed [ACC_W-1:0]  out_o,
  output logic                     out_valid_o
);
  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [COEF_W-1:0] coef;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext, sum, acc_q, out_q;
  logic                     vld_q;

  // coefficient mux, same index as the sample mux
  always_comb begin
    coef = COEFS[COEF_W-1:0];
    for (int i = 0; i < NUM_TAPS; i++)
      if (sel_i == IDX_W'(i)) coef = COEFS[i*COEF_W +: COEF_W];
  end

  assign prod     = PROD_W'(sample_i) * PROD_W'(coef);
  assign prod_ext = ACC_W'(prod);
  assign sum      = acc_q + prod_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else if (clr_i) begin
      acc_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= en_i && last_i;
      if (en_i) acc_q <= last_i ? '0 : sum;
      if (en_i && last_i) out_q <= sum;
    end
  end

  assign out_o       = out_q;
  assign out_valid_o = vld_q;

  logic signed [ACC_W:0] wide_sum;
  assign wide_sum = {acc_q[ACC_W-1], acc_q} + {prod_ext[ACC_W-1], prod_ext};

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> wide_sum[ACC_W] == wide_sum[ACC_W-1]);            // R9
  AST_ACC_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> acc_q == '0);                                    // R6
endmodule

// File: rtl/mac_fir.sv
module mac_fir
  import mac_fir_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int COEF_W   = 16,
  parameter int NUM_TAPS = 8,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = {
    16'sd7, -16'sd300, 16'sd1200, 16'sd9000,
    16'sd9000, 16'sd1200, -16'sd300, 16'sd7}
) (
  input  logic                                               clk_i,
  input  logic                                               rst_ni,
  input  logic                                               clr_i,
  input  logic                                               in_valid_i,
  input  logic signed [DATA_W-1:0]                           in_data_i,
  output logic                                               out_valid_o,
  output logic signed [DATA_W+COEF_W+$clog2(NUM_TAPS)-1:0]   out_data_o,
  output logic                                               busy_o
);
  localparam int IDX_W = idx_width(NUM_TAPS);
  localparam int ACC_W = acc_width(DATA_W, COEF_W, NUM_TAPS);

  logic                     accept, last;
  logic [IDX_W-1:0]         cnt;
  logic signed [DATA_W-1:0] sample;

  mac_fir_seq #(.NUM_TAPS(NUM_TAPS), .IDX_W(IDX_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .in_valid_i(in_valid_i),
    .accept_o(accept), .busy_o(busy_o), .last_o(last), .cnt_o(cnt));

  mac_fir_delay #(.DATA_W(DATA_W), .NUM_TAPS(NUM_TAPS), .IDX_W(IDX_W)) u_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(accept), .din_i(in_data_i),
    .sel_i(cnt), .dout_o(sample));

  mac_fir_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .NUM_TAPS(NUM_TAPS),
                .IDX_W(IDX_W), .ACC_W(ACC_W), .COEFS(COEFS)) u_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .en_i(busy_o),
    .last_i(last), .sel_i(cnt), .sample_i(sample),
    .out_o(out_data_o), .out_valid_o(out_valid_o));

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);                             // R4
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !busy_o);                                  // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !out_valid_o && !busy_o && out_data_o == '0);    // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !last |=> $stable(out_data_o));                  // R8
endmodule

// File: tb/mac_fir_tb.sv
module mac_fir_tb;
  localparam int DW = 16, CW = 16, NT = 8;
  localparam int AW = DW + CW + $clog2(NT);
  localparam logic [NT*CW-1:0] TB_COEFS = {
    16'sd777, -16'sd5, 16'sd1234, 16'sd0,
    16'sd32767, -16'sd32768, 16'sd32767, -16'sd32768};

  logic clk = 1'b0, rst_ni = 1'b0, clr = 1'b0, in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic out_valid, busy;
  logic signed [AW-1:0] out_data;
  int total = 0, bad = 0;
  longint hist [NT];

  always #4 clk = ~clk;

  mac_fir #(.DATA_W(DW), .COEF_W(CW), .NUM_TAPS(NT), .COEFS(TB_COEFS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .in_valid_i(in_valid),
    .in_data_i(in_data), .out_valid_o(out_valid), .out_data_o(out_data),
    .busy_o(busy));

  function automatic longint coef(input int i);
    return longint'($signed(TB_COEFS[i*CW +: CW]));
  endfunction

  function automatic longint model();
    longint s = 0;
    for (int i = 0; i < NT; i++) s += coef(i) * hist[i];
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input longint s);
    for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = s;
  endtask

  // starts at a negedge with the block idle; ends at a negedge
  task automatic sweep(input logic signed [DW-1:0] s, input bit junk);
    longint exp, held;
    chk(busy == 1'b0, "R5 idle before start", busy, 0);
    in_valid = 1'b1; in_data = s;
    @(posedge clk); push(s); @(negedge clk);
    for (int k = 0; k < NT; k++) begin
      chk(busy == 1'b1 && out_valid == 1'b0, "R4/R5 mid sweep", {busy, out_valid}, 2);
      in_valid = junk & $urandom_range(0, 1);   // R2: offered while busy
      in_data = DW'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b0;
    exp = model();
    chk(out_valid == 1'b1, "R4 valid after NUM_TAPS edges", out_valid, 1);
    chk(busy == 1'b0, "R5 busy drops with valid", busy, 0);
    chk(longint'(out_data) == exp, "R3/R2/R6 result", longint'(out_data), exp);
    held = longint'(out_data);
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 single-cycle strobe", out_valid, 0);
    chk(longint'(out_data) == held, "R8 output holds", longint'(out_data), held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NT; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    chk(out_data == '0 && out_valid == 1'b0 && busy == 1'b0, "R1 reset state",
        longint'(out_data), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0, "R1 idle after reset", busy, 0);

    // R3: impulse reads coefficients out in index order; R1 zero history
    sweep(16'sd1, 1'b0);
    for (int i = 0; i < NT - 1; i++) sweep(16'sd0, 1'b0);

    // R7: clear mid sweep with a sample offered in the same cycle
    in_valid = 1'b1; in_data = 16'sd321;
    @(posedge clk); push(321); @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    clr = 1'b1; in_valid = 1'b1; in_data = 16'sd999;
    @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0, "R7 clear aborts sweep", busy, 0);
    chk(out_data == '0, "R7 clear zeroes output", longint'(out_data), 0);
    clr = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R7 clear wins over offered sample", busy, 0);
    sweep(-16'sd77, 1'b1);   // R7: history kept, 999 absent

    // R9: extremes in every tap
    for (int i = 0; i < NT; i++) sweep(-16'sd32768, 1'b1);
    for (int i = 0; i < NT; i++) sweep(16'sd32767, 1'b1);
    for (int i = 0; i < NT; i++) sweep((i % 2) ? 16'sd32767 : -16'sd32768, 1'b0);

    // random, back-to-back and gapped, junk while busy (R2, R6)
    for (int n = 0; n < 60; n++) begin
      sweep(DW'($urandom), 1'b1);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule